// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the feedback divide value and the output divide code of a clock synthesizer and decides, cycle by cycle, where they come from. A parallel path lets the 9-bit feedback value and 3-bit output code flow through while its active-low strobe is low, and freezes them on the strobe's rising edge. A three-wire serial path (clock, data, load) shifts a 12-bit frame into a shift register. While the serial load line is high the frame drives the dividers, and on its falling edge the frame is kept.

All strobes are plain synchronous inputs sampled on the system clock. Edges are found by comparing each strobe with its value on the previous cycle. Every output is registered, so a change at the inputs shows one clock later. The block also decodes the output code into a divide ratio and flags a feedback value outside the usable range. There is no streaming interface: all pins are plain control and status lines, with no valid/ready handshake and no back-pressure.

Top module: `divcfg_loader`

## Requirements
- R1: While `hard_clr` is high, `m_val`, `n_code` and `test_out` are zero, and the shift register is cleared. A serial load issued right after reset therefore yields zero for both values.
- R2: When `par_ld_n` and `ser_ld` are both low, and `ser_ld` was also low on the previous cycle, `m_val` and `n_code` follow `par_m` and `par_n` with one cycle of latency. In that mode `test_out` is low.
- R3: On a rising edge of `par_ld_n` the parallel bus is captured. It stays in force while `par_ld_n` stays high and no serial load event occurs, whatever the bus does.
- R4: Each rising edge of `ser_clk` shifts `ser_dat` into the shift register's LSB. This happens only while `ser_ld` is low, `par_ld_n` is high and the register is not frozen. The frame goes MSB first: bits 11..3 form the feedback value (bit 11 is its weight-256 bit) and bits 2..0 form the output code.
- R5: While `ser_ld` is high, `m_val` and `n_code` show the shift register contents one cycle later, and `ser_clk` edges do not shift.
- R6: A falling edge of `ser_ld` latches the shift register contents as the active values and freezes the shift register. While frozen, `ser_clk` edges change nothing. The freeze clears once `par_ld_n` is low while `ser_ld` is low.
- R7: `ser_ld` high, and the cycle of its falling edge, take priority over a low `par_ld_n`.
- R8: `out_div` decodes `n_code` as follows: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 1, 5 gives 2, 6 gives 4, 7 gives 8.
- R9: `m_range_err` is high exactly when `m_val` is below 125 or above 350. It does not alter the stored value.
- R10: Outside the transparent parallel mode, `test_out` equals bit 11 of the shift register, which is the first bit of the frame shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_clr | input | 1 | Synchronous master reset, active high |
| par_ld_n | input | 1 | Parallel strobe: low is transparent, a rising edge captures |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 3 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load: high drives the frame, a falling edge latches it |
| m_val | output | 9 | Active feedback divide value |
| n_code | output | 3 | Active output divide code |
| out_div | output | 5 | Decoded output divide ratio |
| test_out | output | 1 | Test output: low when transparent, otherwise the shift register MSB |
| m_range_err | output | 1 | Active feedback value lies outside 125..350 |

## Verification
The bench sends serial clock pulses after a serial load has fallen. A design that never froze the shift register would then show a corrupted frame when the load is raised again. It holds `par_ld_n` low while a serial load is active and while it falls. A design with the wrong priority would let the parallel bus leak through on those cycles. It walks all eight output codes, so a ratio table taken as monotonic is caught at codes 4 to 7. It also probes the range edges 124, 125, 350 and 351, where an off-by-one comparison flips the flag. Finally it checks that reset clears the shift register itself and not only the outputs.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  parameter int M_W   = 9;
  parameter int N_W   = 3;
  parameter int FR_W  = M_W + N_W;
  parameter int DIV_W = (1 << (N_W - 1)) + 1;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } cfg_t;

  // Upper code bit set halves the ratio; lower bits select a power of two.
  function automatic logic [DIV_W-1:0] ratio_of(input logic [N_W-1:0] code);
    logic [DIV_W-1:0] r;
    r = DIV_W'(1) << code[N_W-2:0];
    if (!code[N_W-1]) r = r << 1;
    return r;
  endfunction
endpackage

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] sig,
  output logic [W-1:0] prev,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (clr) prev[i] <= 1'b0;
      else     prev[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~prev[i];
    assign fall[i] = ~sig[i] & prev[i];
  end
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift
  import divcfg_pkg::*;
(
  input  logic            clk,
  input  logic            clr,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [FR_W-1:0] sh
);
  always_ff @(posedge clk) begin
    if (clr)           sh <= '0;
    else if (shift_en) sh <= {sh[FR_W-2:0], bit_in};
  end
endmodule

// File: rtl/divcfg_select.sv
module divcfg_select
  import divcfg_pkg::*;
(
  input  logic            clk,
  input  logic            clr,
  input  cfg_t            par_cfg,
  input  logic [FR_W-1:0] sh,
  input  logic            par_low,
  input  logic            par_rise,
  input  logic            ser_high,
  input  logic            ser_fall,
  output cfg_t            cfg,
  output logic            frozen,
  output logic            transp
);
  cfg_t nxt;
  logic nxt_transp;

  // Priority: serial load level, serial fall, parallel transparent, parallel capture.
  always_comb begin
    nxt        = cfg;
    nxt_transp = 1'b0;
    if (ser_high || ser_fall) begin
      nxt = cfg_t'(sh);
    end else if (par_low) begin
      nxt        = par_cfg;
      nxt_transp = 1'b1;
    end else if (par_rise) begin
      nxt = par_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cfg    <= '0;
      transp <= 1'b0;
      frozen <= 1'b0;
    end else begin
      cfg    <= nxt;
      transp <= nxt_transp;
      if (ser_fall)                  frozen <= 1'b1;
      else if (par_low && !ser_high) frozen <= 1'b0;
    end
  end
endmodule

// File: rtl/divcfg_decode.sv
module divcfg_decode
  import divcfg_pkg::*;
#(
  parameter int M_LO = 125,
  parameter int M_HI = 350
) (
  input  cfg_t             cfg,
  output logic [DIV_W-1:0] ratio,
  output logic             range_err
);
  localparam logic [M_W-1:0] LO_V = M_W'(M_LO);
  localparam logic [M_W-1:0] HI_V = M_W'(M_HI);

  assign ratio     = ratio_of(cfg.n);
  assign range_err = (cfg.m < LO_V) || (cfg.m > HI_V);
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int M_LO = 125,
  parameter int M_HI = 350
) (
  input  logic             clk,
  input  logic             hard_clr,
  input  logic             par_ld_n,
  input  logic [M_W-1:0]   par_m,
  input  logic [N_W-1:0]   par_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_ld,
  output logic [M_W-1:0]   m_val,
  output logic [N_W-1:0]   n_code,
  output logic [DIV_W-1:0] out_div,
  output logic             test_out,
  output logic             m_range_err
);
  localparam int IX_SCK = 0;
  localparam int IX_SLD = 1;
  localparam int IX_PLD = 2;
  localparam int NSTB   = 3;

  logic [NSTB-1:0] stb, stb_prev, stb_rise, stb_fall;
  logic [FR_W-1:0] sh_q;
  logic            frozen, transp, shift_en;
  logic            sl_prev, pl_prev;
  cfg_t            cfg, par_cfg;

  assign stb[IX_SCK] = ser_clk;
  assign stb[IX_SLD] = ser_ld;
  assign stb[IX_PLD] = par_ld_n;
  assign sl_prev     = stb_prev[IX_SLD];
  assign pl_prev     = stb_prev[IX_PLD];

  divcfg_edge #(.W(NSTB)) u_edge (
    .clk(clk), .clr(hard_clr), .sig(stb),
    .prev(stb_prev), .rise(stb_rise), .fall(stb_fall)
  );

  assign shift_en = stb_rise[IX_SCK] && !ser_ld && par_ld_n && !frozen;

  divcfg_shift u_shift (
    .clk(clk), .clr(hard_clr), .shift_en(shift_en), .bit_in(ser_dat), .sh(sh_q)
  );

  assign par_cfg = '{m: par_m, n: par_n};

  divcfg_select u_sel (
    .clk(clk), .clr(hard_clr), .par_cfg(par_cfg), .sh(sh_q),
    .par_low(!par_ld_n), .par_rise(stb_rise[IX_PLD]),
    .ser_high(ser_ld), .ser_fall(stb_fall[IX_SLD]),
    .cfg(cfg), .frozen(frozen), .transp(transp)
  );

  divcfg_decode #(.M_LO(M_LO), .M_HI(M_HI)) u_dec (
    .cfg(cfg), .ratio(out_div), .range_err(m_range_err)
  );

  assign m_val    = cfg.m;
  assign n_code   = cfg.n;
  assign test_out = transp ? 1'b0 : sh_q[FR_W-1];
endmodule

// File: rtl/divcfg_checker.sv
module divcfg_checker
  import divcfg_pkg::*;
(
  input logic             clk,
  input logic             hard_clr,
  input logic             par_ld_n,
  input logic [M_W-1:0]   par_m,
  input logic [N_W-1:0]   par_n,
  input logic             ser_ld,
  input logic [M_W-1:0]   m_val,
  input logic [N_W-1:0]   n_code,
  input logic [DIV_W-1:0] out_div,
  input logic             test_out,
  input logic [FR_W-1:0]  sh_q,
  input logic             frozen,
  input logic             sl_prev,
  input logic             pl_prev
);
  p_reset_clear_r1: assert property (@(posedge clk)
    hard_clr |=> (m_val == '0 && n_code == '0 && sh_q == '0 && !test_out));

  p_transparent_r2: assert property (@(posedge clk) disable iff (hard_clr)
    (!par_ld_n && !ser_ld && !sl_prev) |=> (m_val == $past(par_m) && n_code == $past(par_n) && !test_out));

  p_hold_r3: assert property (@(posedge clk) disable iff (hard_clr)
    (par_ld_n && pl_prev && !ser_ld && !sl_prev) |=> $stable({m_val, n_code}));

  p_serial_drive_r5: assert property (@(posedge clk) disable iff (hard_clr)
    ser_ld |=> ({m_val, n_code} == $past(sh_q) && $stable(sh_q)));

  p_frozen_r6: assert property (@(posedge clk) disable iff (hard_clr)
    (frozen && par_ld_n) |=> $stable(sh_q));

  p_ratio_onehot_r8: assert property (@(posedge clk) disable iff (hard_clr)
    $countones(out_div) == 1);
endmodule

bind divcfg_loader divcfg_checker u_chk (
  .clk(clk), .hard_clr(hard_clr), .par_ld_n(par_ld_n), .par_m(par_m), .par_n(par_n),
  .ser_ld(ser_ld), .m_val(m_val), .n_code(n_code), .out_div(out_div), .test_out(test_out),
  .sh_q(sh_q), .frozen(frozen), .sl_prev(sl_prev), .pl_prev(pl_prev)
);

// File: tb/tb_divcfg_loader.sv
`timescale 1ns/1ps
module tb_divcfg_loader;
  logic       clk = 1'b0;
  logic       hard_clr, par_ld_n, ser_clk, ser_dat, ser_ld;
  logic [8:0] par_m;
  logic [2:0] par_n;
  logic [8:0] m_val;
  logic [2:0] n_code;
  logic [4:0] out_div;
  logic       test_out, m_range_err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divcfg_loader dut (
    .clk(clk), .hard_clr(hard_clr), .par_ld_n(par_ld_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .m_val(m_val), .n_code(n_code), .out_div(out_div),
    .test_out(test_out), .m_range_err(m_range_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_frame(input logic [8:0] m, input logic [2:0] n);
    logic [11:0] fr;
    fr = {m, n};
    for (int i = 11; i >= 0; i--) begin
      ser_dat = fr[i]; ser_clk = 1'b1; tick();
      ser_clk = 1'b0; tick();
    end
  endtask

  task automatic t_reset();
    hard_clr = 1'b1; par_ld_n = 1'b0; par_m = 9'd200; par_n = 3'd3;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0;
    tick(3);
    chk("R1 m_val in reset", m_val, 0);
    chk("R1 n_code in reset", n_code, 0);
    chk("R1 test_out in reset", test_out, 0);
    chk("R8 ratio of code 0", out_div, 2);
    chk("R9 flag for m=0", m_range_err, 1);
  endtask

  task automatic t_transparent();
    hard_clr = 1'b0; par_ld_n = 1'b0; par_m = 9'd300; par_n = 3'd3; tick();
    chk("R2 m follows", m_val, 300);
    chk("R2 n follows", n_code, 3);
    chk("R2 test_out low", test_out, 0);
    par_m = 9'd130; tick();
    chk("R2 m follows change", m_val, 130);
  endtask

  task automatic t_capture();
    par_m = 9'd250; par_n = 3'd5; tick();
    par_ld_n = 1'b1; tick();
    par_m = 9'd100; par_n = 3'd1; tick(4);
    chk("R3 m held", m_val, 250);
    chk("R3 n held", n_code, 5);
  endtask

  task automatic t_serial();
    shift_frame(9'd345, 3'd6);
    chk("R3 held during shifting", m_val, 250);
    chk("R10 test_out is frame MSB", test_out, 1);
    ser_ld = 1'b1; tick();
    chk("R4 frame m", m_val, 345);
    chk("R4 frame n", n_code, 6);
    chk("R8 ratio of code 6", out_div, 4);
    ser_dat = 1'b0; ser_clk = 1'b1; tick(); ser_clk = 1'b0; tick();
    chk("R5 no shift while load high", m_val, 345);
    ser_ld = 1'b0; tick(2);
    chk("R6 latched m", m_val, 345);
    chk("R6 latched n", n_code, 6);
    for (int i = 0; i < 3; i++) begin
      ser_dat = 1'b0; ser_clk = 1'b1; tick(); ser_clk = 1'b0; tick();
    end
    chk("R10 test_out after frozen clocks", test_out, 1);
    ser_ld = 1'b1; tick();
    chk("R6 frozen frame m", m_val, 345);
    chk("R6 frozen frame n", n_code, 6);
  endtask

  task automatic t_priority();
    par_ld_n = 1'b0; par_m = 9'd200; par_n = 3'd2; tick(2);
    chk("R7 load high beats parallel", m_val, 345);
    ser_ld = 1'b0; tick();
    chk("R7 fall cycle beats parallel", m_val, 345);
    tick();
    chk("R7 parallel resumes after fall", m_val, 200);
    chk("R2 test_out low again", test_out, 0);
  endtask

  task automatic t_decode();
    int exp_r [8] = '{2, 4, 8, 16, 1, 2, 4, 8};
    for (int c = 0; c < 8; c++) begin
      par_n = 3'(c); tick();
      chk($sformatf("R8 ratio of code %0d", c), out_div, exp_r[c]);
    end
  endtask

  task automatic t_range();
    int mv [6] = '{124, 125, 350, 351, 0, 511};
    int ex [6] = '{1, 0, 0, 1, 1, 1};
    for (int i = 0; i < 6; i++) begin
      par_m = 9'(mv[i]); tick();
      chk($sformatf("R9 flag at m=%0d", mv[i]), m_range_err, ex[i]);
      chk("R9 value kept", m_val, mv[i]);
    end
  endtask

  task automatic t_reload();
    par_ld_n = 1'b1; tick();
    shift_frame(9'd124, 3'd4);
    chk("R10 test_out MSB zero", test_out, 0);
    ser_ld = 1'b1; tick();
    chk("R6 unfrozen reload m", m_val, 124);
    chk("R9 flag on serial m", m_range_err, 1);
    chk("R8 ratio of code 4", out_div, 1);
    ser_ld = 1'b0; tick();
  endtask

  task automatic t_reset_mid();
    hard_clr = 1'b1; tick(2);
    chk("R1 mid reset m", m_val, 0);
    hard_clr = 1'b0; par_ld_n = 1'b1; tick();
    ser_ld = 1'b1; tick();
    chk("R1 shift register cleared m", m_val, 0);
    chk("R1 shift register cleared n", n_code, 0);
    ser_ld = 1'b0; tick();
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_capture();
    t_serial();
    t_priority();
    t_decode();
    t_range();
    t_reload();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule